// File: doc/BRIEF.md
# Battery-Side Power-On Request Controller

This block asks the system supply to turn on while main power is missing. Two independent triggers can raise the request. The first is a calendar alarm: the current date, hour, minute and second all equal their programmed alarm values. The second is an external kick line: it goes low after having been high and then stays low for a minimum number of clock cycles. Both triggers need the same conditions to act. Main power must be absent, the auxiliary battery must be enabled, and the oscillator divider control must be in its running code.

A trigger drives the active-low request output low and sets its own sticky flag: a wake flag for the alarm and a kick flag for the kick line. The request stays low until main power is back and software has cleared both flags. The alarm compare runs only on a once-per-second strobe from the clock core, so one matching second gives exactly one event. The compare is plain equality, so it works the same way whether the time fields hold binary or BCD values.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: If `sec_tick` is high for one cycle and all four current fields equal their alarm fields, with `wake_en`=1 and the block armed, `wake_flag` is 1 and `pwr_req_n` is 0 from the second rising edge after the tick edge onward.
- R2: A difference in any single field (date, hour, minute or second) gives no wake event. Values in binary and in BCD behave the same way.
- R3: With `wake_en`=0 a matching tick sets no flag and leaves `pwr_req_n` at 1.
- R4: `kick_n` low for at least KICK_MIN_CYC consecutive clock samples, after having been high, sets `kick_flag` and drives `pwr_req_n` low. A shorter low pulse has no effect.
- R5: With `kick_en`=0 a valid kick pulse has no effect.
- R6: The block is armed only while `main_pwr`=0 and `aux_en`=1. Otherwise neither trigger sets a flag or lowers `pwr_req_n`.
- R7: The block is armed only when `div_ctl[2:1]`=2'b01. The value of `div_ctl[0]` does not matter.
- R8: Without `sec_tick`, a standing match gives no event. Each tick with a match gives one event.
- R9: Once low, `pwr_req_n` returns to 1 only when `main_pwr`=1 and both flags are 0.
- R10: A one-cycle `wflag_clr` or `kflag_clr` pulse clears its flag. If a set and a clear arrive in the same cycle, the set wins.
- R11: Reset leaves both flags at 0 and `pwr_req_n` at 1.
- R12: A kick line that is held low gives one event only. A line that is low from reset onward gives none, because a high level must come first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cur_date | input | FIELD_W | Current day of month |
| cur_hour | input | FIELD_W | Current hour |
| cur_min | input | FIELD_W | Current minute |
| cur_sec | input | FIELD_W | Current second |
| alm_date | input | FIELD_W | Date alarm value |
| alm_hour | input | FIELD_W | Hour alarm value |
| alm_min | input | FIELD_W | Minute alarm value |
| alm_sec | input | FIELD_W | Second alarm value |
| wake_en | input | 1 | Alarm trigger enable |
| kick_en | input | 1 | Kick trigger enable |
| div_ctl | input | 3 | Oscillator divider control field |
| main_pwr | input | 1 | Main supply present |
| aux_en | input | 1 | Auxiliary battery enable |
| kick_n | input | 1 | Asynchronous active-low kick line |
| wflag_clr | input | 1 | Write-zero strobe for the wake flag |
| kflag_clr | input | 1 | Write-zero strobe for the kick flag |
| pwr_req_n | output | 1 | Active-low power request |
| wake_flag | output | 1 | Sticky alarm-event flag |
| kick_flag | output | 1 | Sticky kick-event flag |

## Verification
The alarm path is tried with full matches and with a mismatch in each single field. Both binary and BCD encodings of the same time are used, which shows whether every field takes part in the compare and whether the compare depends on the encoding. All eight divider codes and every combination of main power, battery enable and trigger enable are swept for both triggers, which separates the gating terms from each other. Kick pulses are swept in width around KICK_MIN_CYC to pin down the exact threshold. A line held low and a line low from reset show the difference between edge detection and level detection.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  // Divider-control upper bits that mean "oscillator running, chain released"
  localparam logic [1:0] DIV_RUN = 2'b01;
  // Number of compared calendar fields (date, hour, minute, second)
  localparam int N_FIELDS = 4;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import pwr_wake_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic [N_FIELDS*FIELD_W-1:0]   now_v,
  input  logic [N_FIELDS*FIELD_W-1:0]   alm_v,
  output logic                          hit
);
  logic [N_FIELDS-1:0] eq;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    assign eq[i] = (now_v[i*FIELD_W +: FIELD_W] == alm_v[i*FIELD_W +: FIELD_W]);
  end

  // Sampled only on the seconds strobe: one event per matching tick
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= tick & (&eq);
  end
endmodule

// File: rtl/kick_filter.sv
module kick_filter #(
  parameter int MIN_PW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_n,
  output logic hit
);
  localparam int CW = $clog2(MIN_PW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_PW);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  // Synchronizer resets low so a line held low through reset never fires
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= kick_n;
      s2 <= s1;
    end
  end

  // Low-time counter: restarts on high, saturates at MIN_PW after firing once
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_MAX;
      hit <= 1'b0;
    end else if (s2) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
      hit <= (cnt == CNT_MAX - 1'b1);
    end else begin
      hit <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int FIELD_W      = 8,
  parameter int KICK_MIN_CYC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic               wake_en,
  input  logic               kick_en,
  input  logic [2:0]         div_ctl,
  input  logic               main_pwr,
  input  logic               aux_en,
  input  logic               kick_n,
  input  logic               wflag_clr,
  input  logic               kflag_clr,
  output logic               pwr_req_n,
  output logic               wake_flag,
  output logic               kick_flag
);
  logic wake_hit, kick_hit, armed, wake_evt, kick_evt;

  alarm_match #(.FIELD_W(FIELD_W)) u_match (
    .clk   (clk),
    .rst   (rst),
    .tick  (sec_tick),
    .now_v ({cur_date, cur_hour, cur_min, cur_sec}),
    .alm_v ({alm_date, alm_hour, alm_min, alm_sec}),
    .hit   (wake_hit)
  );

  kick_filter #(.MIN_PW(KICK_MIN_CYC)) u_kick (
    .clk    (clk),
    .rst    (rst),
    .kick_n (kick_n),
    .hit    (kick_hit)
  );

  assign armed    = !main_pwr && aux_en && (div_ctl[2:1] == DIV_RUN);
  assign wake_evt = wake_hit && wake_en && armed;
  assign kick_evt = kick_hit && kick_en && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_flag <= 1'b0;
      kick_flag <= 1'b0;
      pwr_req_n <= 1'b1;
    end else begin
      if (wake_evt)       wake_flag <= 1'b1;
      else if (wflag_clr) wake_flag <= 1'b0;
      if (kick_evt)       kick_flag <= 1'b1;
      else if (kflag_clr) kick_flag <= 1'b0;
      if (wake_evt || kick_evt)
        pwr_req_n <= 1'b0;
      else if (main_pwr && !wake_flag && !kick_flag)
        pwr_req_n <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] div_ctl,
  input logic       main_pwr,
  input logic       aux_en,
  input logic       wflag_clr,
  input logic       kflag_clr,
  input logic       pwr_req_n,
  input logic       wake_flag,
  input logic       kick_flag
);
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (pwr_req_n && !wake_flag && !kick_flag));

  a_r1_req_with_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_req_n) |-> (wake_flag || kick_flag));

  a_r6_armed_only: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake_flag) || $rose(kick_flag)) |-> $past(!main_pwr && aux_en));

  a_r7_divider_run: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake_flag) || $rose(kick_flag)) |-> $past(div_ctl[2:1] == 2'b01));

  a_r9_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!pwr_req_n && !(main_pwr && !wake_flag && !kick_flag)) |=> !pwr_req_n);

  a_r10_wclr_only: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_flag) |-> $past(wflag_clr));

  a_r10_kclr_only: assert property (@(posedge clk) disable iff (rst)
    $fell(kick_flag) |-> $past(kflag_clr));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .div_ctl   (div_ctl),
  .main_pwr  (main_pwr),
  .aux_en    (aux_en),
  .wflag_clr (wflag_clr),
  .kflag_clr (kflag_clr),
  .pwr_req_n (pwr_req_n),
  .wake_flag (wake_flag),
  .kick_flag (kick_flag)
);

// File: tb/test_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module test_pwr_wake_ctrl;
  localparam int W   = 8;
  localparam int MPW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 0;
  logic [W-1:0] cur_date = 0, cur_hour = 0, cur_min = 0, cur_sec = 0;
  logic [W-1:0] alm_date = 0, alm_hour = 0, alm_min = 0, alm_sec = 0;
  logic wake_en = 0, kick_en = 0, main_pwr = 0, aux_en = 1, kick_n = 1;
  logic [2:0] div_ctl = 3'b010;
  logic wflag_clr = 0, kflag_clr = 0;
  logic pwr_req_n, wake_flag, kick_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl #(.FIELD_W(W), .KICK_MIN_CYC(MPW)) i_pwr_wake_ctrl (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cur_date(cur_date), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .wake_en(wake_en), .kick_en(kick_en), .div_ctl(div_ctl), .main_pwr(main_pwr),
    .aux_en(aux_en), .kick_n(kick_n), .wflag_clr(wflag_clr), .kflag_clr(kflag_clr),
    .pwr_req_n(pwr_req_n), .wake_flag(wake_flag), .kick_flag(kick_flag)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // Bring power back, clear both flags, confirm release, then go back to battery
  task automatic recover(input string req);
    @(negedge clk); main_pwr = 1; wflag_clr = 1; kflag_clr = 1;
    @(negedge clk); wflag_clr = 0; kflag_clr = 0;
    repeat (2) @(negedge clk);
    chk(req, "released", {5'd0, pwr_req_n, wake_flag, kick_flag}, 8'b100);
    main_pwr = 0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [W-1:0] d, h, m, s);
    cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  task automatic set_alm(input logic [W-1:0] d, h, m, s);
    alm_date = d; alm_hour = h; alm_min = m; alm_sec = s;
  endtask

  // One seconds strobe; outputs sampled after the second edge following it
  task automatic tick_and_check(input string req, input logic exp);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    @(negedge clk);
    chk(req, "wake_flag", {7'd0, wake_flag}, {7'd0, exp});
    chk(req, "pwr_req_n", {7'd0, pwr_req_n}, {7'd0, !exp});
    if (exp) recover(req);
  endtask

  task automatic kick_pulse(input string req, input int width, input logic exp);
    @(negedge clk); kick_n = 0;
    repeat (width) @(negedge clk);
    kick_n = 1;
    repeat (MPW + 6) @(negedge clk);
    chk(req, "kick_flag", {7'd0, kick_flag}, {7'd0, exp});
    chk(req, "pwr_req_n", {7'd0, pwr_req_n}, {7'd0, !exp});
    if (exp) recover(req);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R11: reset state
    chk("R11", "reset", {5'd0, pwr_req_n, wake_flag, kick_flag}, 8'b100);

    wake_en = 1;
    // R1/R2: binary then BCD encodings of 23:59:58 on day 31
    for (int enc = 0; enc < 2; enc++) begin
      logic [W-1:0] d, h, m, s;
      d = enc ? 8'h31 : 8'd31; h = enc ? 8'h23 : 8'd23;
      m = enc ? 8'h59 : 8'd59; s = enc ? 8'h58 : 8'd58;
      set_alm(d, h, m, s);
      set_time(d, h, m, s);
      tick_and_check("R1", 1'b1);
      for (int f = 0; f < 4; f++) begin
        set_time(d ^ W'(f == 0), h ^ W'(f == 1), m ^ W'(f == 2), s ^ W'(f == 3));
        tick_and_check("R2", 1'b0);
        set_time(d, h, m, s);
      end
    end

    // R7: all divider codes, armed only when upper two bits are 01
    for (int dv = 0; dv < 8; dv++) begin
      div_ctl = 3'(dv);
      tick_and_check("R7", (dv >> 1) == 1);
    end
    div_ctl = 3'b011;

    // R3/R6: sweep enable, main power and battery enable
    for (int v = 0; v < 8; v++) begin
      logic exp;
      wake_en = v[0]; main_pwr = v[1]; aux_en = v[2];
      exp = v[0] && !v[1] && v[2];
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
      @(negedge clk);
      chk(v[0] ? "R6" : "R3", "wake_flag", {7'd0, wake_flag}, {7'd0, exp});
      main_pwr = 0;
      if (exp) recover("R6");
    end
    wake_en = 1; aux_en = 1; main_pwr = 0;

    // R8: standing match without tick gives nothing
    repeat (10) @(negedge clk);
    chk("R8", "no tick", {7'd0, wake_flag}, 8'd0);

    // R10: set wins over simultaneous clear
    @(negedge clk); sec_tick = 1; wflag_clr = 1;
    @(negedge clk); sec_tick = 0;
    @(negedge clk); wflag_clr = 0;
    chk("R10", "set wins", {7'd0, wake_flag}, 8'd1);

    // R9: power back but flag set keeps request low; flag clear on battery keeps it low
    @(negedge clk); main_pwr = 1;
    repeat (3) @(negedge clk);
    chk("R9", "flag still set", {7'd0, pwr_req_n}, 8'd0);
    main_pwr = 0; wflag_clr = 1;
    @(negedge clk); wflag_clr = 0;
    repeat (3) @(negedge clk);
    chk("R10", "wflag cleared", {7'd0, wake_flag}, 8'd0);
    chk("R9", "no main power", {7'd0, pwr_req_n}, 8'd0);
    main_pwr = 1;
    repeat (3) @(negedge clk);
    chk("R9", "release", {7'd0, pwr_req_n}, 8'd1);
    main_pwr = 0;
    wake_en = 0;

    // R4: pulse width sweep around the minimum
    kick_en = 1;
    for (int wd = 1; wd <= MPW + 2; wd++)
      kick_pulse("R4", wd, wd >= MPW);

    // R5/R6: gating sweep for the kick trigger
    for (int v = 0; v < 8; v++) begin
      logic exp;
      kick_en = v[0]; main_pwr = v[1]; aux_en = v[2];
      exp = v[0] && !v[1] && v[2];
      @(negedge clk); kick_n = 0;
      repeat (MPW + 1) @(negedge clk);
      kick_n = 1;
      repeat (6) @(negedge clk);
      chk(v[0] ? "R6" : "R5", "kick_flag", {7'd0, kick_flag}, {7'd0, exp});
      main_pwr = 0;
      if (exp) recover("R6");
    end
    kick_en = 1; aux_en = 1; main_pwr = 0;

    // R12: held low gives one event only
    @(negedge clk); kick_n = 0;
    repeat (MPW * 3) @(negedge clk);
    chk("R12", "first event", {7'd0, kick_flag}, 8'd1);
    kflag_clr = 1;
    @(negedge clk); kflag_clr = 0;
    repeat (MPW * 3) @(negedge clk);
    chk("R12", "no re-fire", {7'd0, kick_flag}, 8'd0);
    kick_n = 1;
    recover("R12");

    // R12: low from reset never fires
    kick_n = 0;
    do_reset();
    repeat (MPW * 3) @(negedge clk);
    chk("R12", "low from reset", {6'd0, kick_flag, pwr_req_n}, 8'b01);
    kick_n = 1;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule